// File: doc/BRIEF.md
# Masked Interrupt Status Controller with Rotating Service Selection

This block collects a vector of level-sensitive interrupt sources (32 or 64 of them, fixed by a parameter) and gates that vector with an enable mask held in the block. The pending vector is the bitwise AND of the raw source levels and the mask. A single combined line toward the processor, meant for processor interrupt input 2, is high whenever any enabled source is pending. Source levels are never cleared here: each source drops its own line once it has been serviced.

Software reaches the block through a small register bus. The bus reads the raw levels, the mask and the pending vector. It writes the whole mask at once, or sets or clears one mask bit by index without touching the others. A separate one-cycle `take_next` strobe asks which source to service next. The answer is fair: the search starts at a stored pointer and walks upward with wrap-around. The first pending index found is reported, and the pointer moves to the position just past it. The answer is registered and appears one cycle after the strobe as a one-cycle `sel_valid` pulse. The strobe is not a data stream, so it has no back-pressure: each strobe is always accepted and always answered.

An optional contiguous window of source indices can be marked as cascaded external lines. A selected index inside that window is also reported as an external line number, counted from the start of the window.

Top module: `irqc_top`

## Requirements
- R1: The pending vector equals raw source levels AND mask, and it reads back on `bus_rdata` when `bus_addr` is 2 with `bus_en` high. The raw levels read back when `bus_addr` is 0.
- R2: `irq_to_cpu` is high in the same cycle exactly when the pending vector is non-zero.
- R3: After reset the mask is all zeros, `sel_valid` is low, and the search pointer is 0, so the first selection with every source pending is index 0.
- R4: A write with `bus_addr` 1 replaces the whole mask with `bus_wdata`, and a read of address 1 returns the mask.
- R5: A write with `bus_addr` 3 sets the single mask bit whose index is in the low bits of `bus_wdata`. A write with `bus_addr` 4 clears that single bit. All other mask bits are left unchanged.
- R6: `sel_valid` is high for exactly the one cycle after each cycle in which `take_next` is high, and low otherwise.
- R7: On a strobe with something pending, the reported `sel_index` is the first pending index at or after the pointer, taken in increasing order modulo the width. The pointer then becomes that index plus one, modulo the width. `sel_found` is 1.
- R8: On a strobe with nothing pending, `sel_found`, `sel_index`, `sel_is_ext` and `sel_ext_line` are 0 and the pointer does not move.
- R9: With cascading enabled, a selected index from `EXT_FIRST` to `EXT_LAST` inclusive gives `sel_is_ext` = 1 and `sel_ext_line` = index − `EXT_FIRST`. Any other index gives `sel_is_ext` = 0 and `sel_ext_line` = 0.
- R10: A selection does not clear or alter any source level: the raw read still returns `src_i` after any number of strobes.
- R11: Writes to the read-only addresses 0 and 2 leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | SRC_W | Raw level-sensitive source lines |
| bus_en | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | 0 raw, 1 mask, 2 pending, 3 set bit, 4 clear bit |
| bus_wdata | input | SRC_W | Write data (mask value or bit index in low bits) |
| bus_rdata | output | SRC_W | Combinational read data, 0 when not reading |
| take_next | input | 1 | Request the next source to service |
| sel_valid | output | 1 | One-cycle pulse carrying the answer to a strobe |
| sel_found | output | 1 | A pending source was selected |
| sel_index | output | log2(SRC_W) | Selected source index |
| sel_is_ext | output | 1 | Selected index lies in the cascaded window |
| sel_ext_line | output | LINE_W | External line number within the window |
| irq_to_cpu | output | 1 | Combined interrupt toward processor input 2 |

## Verification
The bench builds the block at 64 sources with cascading on and a window from 8 to 11. That width makes the pointer wrap from 63 back to 0 reachable. The window puts indices 7, 8, 11 and 12 directly on either side of both window edges. Directed sequences cover the first selection after reset, empty strobes between busy ones, and wrap-around. Long random runs of mask, source and strobe changes are then compared against a bench model of the pointer and the mask.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    REG_RAW  = 3'd0,
    REG_MASK = 3'd1,
    REG_PEND = 3'd2,
    REG_SET  = 3'd3,
    REG_CLR  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/irqc_mask_regs.sv
module irqc_mask_regs
  import irqc_pkg::*;
#(
  parameter int SRC_W = 64,
  parameter int IDX_W = $clog2(SRC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [SRC_W-1:0] wr_data,
  output logic [SRC_W-1:0] mask_q
);
  logic [IDX_W-1:0] wr_idx;
  assign wr_idx = wr_data[IDX_W-1:0];

  // one flop per source; set/clear by index touch only the addressed bit (R5)
  for (genvar b = 0; b < SRC_W; b++) begin : g_bit
    logic hit;
    assign hit = (wr_idx == IDX_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[b] <= 1'b0;
      end else if (wr_en) begin
        case (wr_sel)
          REG_MASK: mask_q[b] <= wr_data[b];
          REG_SET:  if (hit) mask_q[b] <= 1'b1;
          REG_CLR:  if (hit) mask_q[b] <= 1'b0;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_rr_pick.sv
module irqc_rr_pick #(
  parameter int SRC_W = 64,
  parameter int IDX_W = $clog2(SRC_W)
) (
  input  logic [SRC_W-1:0] pend,
  input  logic [IDX_W-1:0] start,
  output logic             any,
  output logic [IDX_W-1:0] pick
);
  // walk from start upward with natural wrap of the index width;
  // scanning offsets high to low leaves the nearest hit in pick
  always_comb begin
    pick = '0;
    for (int i = SRC_W - 1; i >= 0; i--) begin
      if (pend[IDX_W'(start + IDX_W'(i))]) pick = IDX_W'(start + IDX_W'(i));
    end
  end
  assign any = |pend;
endmodule

// File: rtl/irqc_ext_map.sv
module irqc_ext_map #(
  parameter int IDX_W      = 6,
  parameter bit CASCADE_EN = 1'b1,
  parameter int EXT_FIRST  = 8,
  parameter int EXT_LAST   = 11,
  parameter int LINE_W     = 2
) (
  input  logic [IDX_W-1:0]  idx,
  output logic              is_ext,
  output logic [LINE_W-1:0] line
);
  if (CASCADE_EN) begin : g_casc
    logic in_win;
    assign in_win = (idx >= IDX_W'(EXT_FIRST)) && (idx <= IDX_W'(EXT_LAST));
    assign is_ext = in_win;
    assign line   = in_win ? LINE_W'(idx - IDX_W'(EXT_FIRST)) : '0;
  end else begin : g_flat
    logic unused_idx;
    assign unused_idx = ^idx;
    assign is_ext = 1'b0;
    assign line   = '0;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int SRC_W      = 64,
  parameter bit CASCADE_EN = 1'b1,
  parameter int EXT_FIRST  = 8,
  parameter int EXT_LAST   = 11,
  localparam int IDX_W     = $clog2(SRC_W),
  localparam int SPAN      = EXT_LAST - EXT_FIRST + 1,
  localparam int LINE_W    = (SPAN > 1) ? $clog2(SPAN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [SRC_W-1:0]  bus_wdata,
  output logic [SRC_W-1:0]  bus_rdata,
  input  logic              take_next,
  output logic              sel_valid,
  output logic              sel_found,
  output logic [IDX_W-1:0]  sel_index,
  output logic              sel_is_ext,
  output logic [LINE_W-1:0] sel_ext_line,
  output logic              irq_to_cpu
);
  reg_sel_e          bus_sel;
  logic [SRC_W-1:0]  mask_q;
  logic [SRC_W-1:0]  pend;
  logic [IDX_W-1:0]  ptr_q;
  logic              any_pend;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_ext;
  logic [LINE_W-1:0] pick_line;

  assign bus_sel = reg_sel_e'(bus_addr);

  irqc_mask_regs #(.SRC_W(SRC_W), .IDX_W(IDX_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_en & bus_we),
    .wr_sel  (bus_sel),
    .wr_data (bus_wdata),
    .mask_q  (mask_q)
  );

  assign pend       = src_i & mask_q;
  assign irq_to_cpu = |pend;

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (bus_sel)
        REG_RAW:  bus_rdata = src_i;
        REG_MASK: bus_rdata = mask_q;
        REG_PEND: bus_rdata = pend;
        default:  bus_rdata = '0;
      endcase
    end
  end

  irqc_rr_pick #(.SRC_W(SRC_W), .IDX_W(IDX_W)) u_pick (
    .pend  (pend),
    .start (ptr_q),
    .any   (any_pend),
    .pick  (pick_idx)
  );

  irqc_ext_map #(
    .IDX_W(IDX_W), .CASCADE_EN(CASCADE_EN),
    .EXT_FIRST(EXT_FIRST), .EXT_LAST(EXT_LAST), .LINE_W(LINE_W)
  ) u_map (
    .idx    (pick_idx),
    .is_ext (pick_ext),
    .line   (pick_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q        <= '0;
      sel_valid    <= 1'b0;
      sel_found    <= 1'b0;
      sel_index    <= '0;
      sel_is_ext   <= 1'b0;
      sel_ext_line <= '0;
    end else begin
      sel_valid <= take_next;
      if (take_next) begin
        if (any_pend) begin
          sel_found    <= 1'b1;
          sel_index    <= pick_idx;
          sel_is_ext   <= pick_ext;
          sel_ext_line <= pick_line;
          ptr_q        <= pick_idx + 1'b1;
        end else begin
          sel_found    <= 1'b0;
          sel_index    <= '0;
          sel_is_ext   <= 1'b0;
          sel_ext_line <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int SRC_W      = 64,
  parameter bit CASCADE_EN = 1'b1,
  parameter int EXT_FIRST  = 8,
  parameter int EXT_LAST   = 11,
  parameter int IDX_W      = $clog2(SRC_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             take_next,
  input logic             sel_valid,
  input logic             sel_found,
  input logic [IDX_W-1:0] sel_index,
  input logic             sel_is_ext,
  input logic             irq_to_cpu,
  input logic             bus_en,
  input logic             bus_we,
  input logic [2:0]       bus_addr,
  input logic [IDX_W-1:0] wr_idx,
  input logic [SRC_W-1:0] mask_q,
  input logic [IDX_W-1:0] ptr_q
);
  logic [SRC_W-1:0] onehot_w;
  assign onehot_w = SRC_W'(1) << wr_idx;

  p_valid_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_next |=> sel_valid);
  p_no_valid_without_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !take_next |=> !sel_valid);
  p_found_needs_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && sel_found |-> $past(irq_to_cpu));
  p_ptr_past_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && sel_found |-> ptr_q == IDX_W'(sel_index + 1'b1));
  p_empty_holds_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && !sel_found |-> !$past(irq_to_cpu) && ptr_q == $past(ptr_q));
  p_ext_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && sel_is_ext |-> CASCADE_EN && sel_found &&
      sel_index >= IDX_W'(EXT_FIRST) && sel_index <= IDX_W'(EXT_LAST));
  p_set_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && bus_we && bus_addr == 3'd3 |=>
      (((mask_q ^ $past(mask_q)) & ~$past(onehot_w)) == '0) &&
      ((mask_q & $past(onehot_w)) != '0));
  p_clr_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && bus_we && bus_addr == 3'd4 |=>
      (((mask_q ^ $past(mask_q)) & ~$past(onehot_w)) == '0) &&
      ((mask_q & $past(onehot_w)) == '0));
  p_ro_write_keeps_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && bus_we && (bus_addr == 3'd0 || bus_addr == 3'd2) |=> $stable(mask_q));
  p_no_mask_no_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q == '0 |-> !irq_to_cpu);
endmodule

bind irqc_top irqc_chk #(
  .SRC_W(SRC_W), .CASCADE_EN(CASCADE_EN),
  .EXT_FIRST(EXT_FIRST), .EXT_LAST(EXT_LAST)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .take_next  (take_next),
  .sel_valid  (sel_valid),
  .sel_found  (sel_found),
  .sel_index  (sel_index),
  .sel_is_ext (sel_is_ext),
  .irq_to_cpu (irq_to_cpu),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .wr_idx     (bus_wdata[IDX_W-1:0]),
  .mask_q     (mask_q),
  .ptr_q      (ptr_q)
);

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/100ps
module irqc_top_tb_top;
  localparam int W  = 64;
  localparam int IW = 6;
  localparam int EF = 8;
  localparam int EL = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  src = '0;
  logic          bus_en = 1'b0;
  logic          bus_we = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic          take_next = 1'b0;
  logic          sel_valid, sel_found, sel_is_ext, irq_to_cpu;
  logic [IW-1:0] sel_index;
  logic [1:0]    sel_ext_line;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] mask_m = '0;
  int ptr_m = 0;

  always #2.5 clk = ~clk;

  irqc_top #(.SRC_W(W), .CASCADE_EN(1'b1), .EXT_FIRST(EF), .EXT_LAST(EL)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .take_next(take_next), .sel_valid(sel_valid), .sel_found(sel_found),
    .sel_index(sel_index), .sel_is_ext(sel_is_ext),
    .sel_ext_line(sel_ext_line), .irq_to_cpu(irq_to_cpu)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int pick(input logic [W-1:0] p, input int start);
    for (int k = 0; k < W; k++) begin
      if (p[(start + k) % W]) return (start + k) % W;
    end
    return -1;
  endfunction

  task automatic bus_wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic set_src(input logic [W-1:0] v);
    @(negedge clk);
    src = v;
    #1 chk("R2 irq_to_cpu", 64'(irq_to_cpu), 64'(|(v & mask_m)));
  endtask

  task automatic take_chk();
    logic [W-1:0] p;
    int idx;
    bit ext;
    p = src & mask_m;
    idx = pick(p, ptr_m);
    @(negedge clk);
    take_next = 1'b1;
    @(negedge clk);
    take_next = 1'b0;
    chk("R6 sel_valid after strobe", 64'(sel_valid), 64'd1);
    if (idx < 0) begin
      chk("R8 sel_found empty", 64'(sel_found), 64'd0);
      chk("R8 sel_index empty", 64'(sel_index), 64'd0);
      chk("R8 sel_is_ext empty", 64'(sel_is_ext), 64'd0);
    end else begin
      ext = (idx >= EF) && (idx <= EL);
      chk("R7 sel_found", 64'(sel_found), 64'd1);
      chk("R7 sel_index", 64'(sel_index), 64'(idx));
      chk("R9 sel_is_ext", 64'(sel_is_ext), 64'(ext));
      chk("R9 sel_ext_line", 64'(sel_ext_line), ext ? 64'(idx - EF) : 64'd0);
      ptr_m = (idx + 1) % W;
    end
    @(negedge clk);
    chk("R6 sel_valid single cycle", 64'(sel_valid), 64'd0);
  endtask

  initial begin : main
    logic [W-1:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R3 sel_valid in reset", 64'(sel_valid), 64'd0);
    rst_n = 1'b1;
    bus_rd(3'd1, d);
    chk("R3 mask after reset", d, '0);
    set_src('1);
    chk("R3 irq low with zero mask", 64'(irq_to_cpu), 64'd0);

    // R4 full mask write and readback
    bus_wr(3'd1, 64'hA5A5_0F0F_1234_8001);
    mask_m = 64'hA5A5_0F0F_1234_8001;
    bus_rd(3'd1, d);
    chk("R4 mask readback", d, mask_m);
    bus_rd(3'd2, d);
    chk("R1 pending read", d, src & mask_m);
    bus_wr(3'd1, '1);
    mask_m = '1;

    // R3/R7 pointer starts at 0, then steps
    take_chk();
    take_chk();
    take_chk();
    // R8 empty strobe leaves pointer, then wrap
    set_src('0);
    take_chk();
    set_src((64'd1 << 5) | (64'd1 << 2));
    take_chk();
    take_chk();
    set_src((64'd1 << 63) | 64'd1);
    take_chk();
    take_chk();
    // R9 window edges
    set_src((64'd1 << 7) | (64'd1 << 8) | (64'd1 << 11) | (64'd1 << 12));
    for (int k = 0; k < 5; k++) take_chk();
    // R10 levels not cleared
    bus_rd(3'd0, d);
    chk("R10 raw unchanged", d, src);

    // R5 single-bit set and clear
    bus_wr(3'd1, '0);
    mask_m = '0;
    bus_wr(3'd3, 64'd10);
    mask_m[10] = 1'b1;
    bus_wr(3'd3, 64'd63);
    mask_m[63] = 1'b1;
    bus_rd(3'd1, d);
    chk("R5 set bits", d, mask_m);
    bus_wr(3'd4, 64'd10);
    mask_m[10] = 1'b0;
    bus_rd(3'd1, d);
    chk("R5 clear bit", d, mask_m);

    // R11 read-only addresses
    bus_wr(3'd0, 64'h0123_4567_89AB_CDEF);
    bus_wr(3'd2, '1);
    bus_rd(3'd1, d);
    chk("R11 mask kept", d, mask_m);

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [W-1:0] r;
      op = int'($urandom_range(0, 5));
      r = {$urandom, $urandom};
      case (op)
        0: begin bus_wr(3'd1, r); mask_m = r; end
        1: begin bus_wr(3'd3, 64'(r[5:0])); mask_m[r[5:0]] = 1'b1; end
        2: begin bus_wr(3'd4, 64'(r[5:0])); mask_m[r[5:0]] = 1'b0; end
        3: set_src(r & {$urandom, $urandom} & {$urandom, $urandom});
        default: take_chk();
      endcase
      if (it % 50 == 0) begin
        bus_rd(3'd2, d);
        chk("R1 pending random", d, src & mask_m);
        bus_rd(3'd0, d);
        chk("R10 raw random", d, src);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule